// File: doc/BRIEF.md
# Shift-and-Blend Mask Unit

This execution unit produces a mask-style result in one operation. It first sends a second operand through a barrel shifter (left, logical right or arithmetic right, by a 5-bit amount) to form a mask value. It then merges that mask with a base operand: it can pass the mask through, AND it with the base, OR it with the base, or XOR it with the base.

A 9-bit control word selects the blend, the shift kind and the amount. One shift code is reserved. When that code arrives, the unit raises an illegal flag and withholds the write-enable.

The result leaves through one registered stage with a valid/ready handshake. A result is held until downstream accepts it. Operand fetch, instruction decode and register write-back belong to the surrounding pipeline.

Top module: `shblend_unit`

## Requirements
- R1: The control word `ctrl_i` is decoded as follows: bits 8:7 select the blend, bits 6:5 select the shift kind, and bits 4:0 hold the shift amount.
- R2: Shift code 2'b00 shifts the second operand left by the amount and fills with zeros.
- R3: Shift code 2'b01 shifts the second operand right by the amount and fills with zeros.
- R4: Shift code 2'b10 shifts the second operand right by the amount and fills with copies of its bit 31.
- R5: A shift amount of 0 leaves the second operand unchanged in all three legal shift codes.
- R6: Shift code 2'b11 is reserved. The registered result is then all zeros, `illegal_o` is 1 and `wr_en_o` is 0.
- R7: Blend code 2'b00 outputs the mask value and ignores the base operand.
- R8: Blend codes 2'b01, 2'b10 and 2'b11 output the base operand AND, OR and XOR the mask value, respectively.
- R9: `in_ready_o` is high exactly when the stage is empty or `out_ready_i` is high. An accepted input appears on the outputs with `out_valid_o` high after the next rising clock edge. A held result with `out_ready_i` high and no new input leaves the stage after one edge.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `result_o`, `wr_en_o` and `illegal_o` keep their values.
- R11: After reset, `out_valid_o`, `wr_en_o`, `illegal_o` and `result_o` are all zero.
- R12: `wr_en_o` and `illegal_o` are both low whenever `out_valid_o` is low. While `out_valid_o` is high, exactly one of them is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Stage can take an operation |
| base_i | input | 32 | Base operand for the blend |
| operand_i | input | 32 | Operand that is shifted into the mask |
| ctrl_i | input | 9 | Blend code, shift code and shift amount |
| out_valid_o | output | 1 | Registered result present |
| out_ready_i | input | 1 | Downstream accepts the result |
| result_o | output | 32 | Blended result |
| wr_en_o | output | 1 | Result may be written back |
| illegal_o | output | 1 | Reserved shift code was used |

## Verification
The bench targets the fill behaviour at the extremes:
- An amount of 31 on a negative operand under arithmetic right shift. A design that zero-fills there returns 1 instead of all ones.
- The same pattern under logical right shift. A design that sign-fills there leaks ones into the top bits.
- An amount of 0 in every shift kind. This exposes a shifter that drops or wraps a bit.

The reserved shift code is sent with nonzero operands. A unit that still wrote back, or that let the shifted value through, would show a live write-enable or a nonzero result.

Stalls of random length check that a held result neither changes nor is lost. A back-to-back pair checks that a ready downstream gets one result per cycle with no bubble.

// File: rtl/shb_pkg.sv
package shb_pkg;

   typedef enum logic [1:0] {
      SHF_LEFT   = 2'b00,
      SHF_LRIGHT = 2'b01,
      SHF_ARIGHT = 2'b10,
      SHF_RSVD   = 2'b11
   } shf_mode_e;

   typedef enum logic [1:0] {
      BLD_MOVE = 2'b00,
      BLD_AND  = 2'b01,
      BLD_OR   = 2'b10,
      BLD_XOR  = 2'b11
   } bld_mode_e;

   localparam int MODE_W = 2;

   function automatic logic is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/shb_ctrl_decode.sv
module shb_ctrl_decode
   import shb_pkg::*;
#(
   parameter int AMT_W = 5,
   localparam int SHF_LSB = AMT_W,
   localparam int BLD_LSB = AMT_W + MODE_W,
   localparam int CTRL_W  = AMT_W + 2 * MODE_W
) (
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic [AMT_W-1:0]  amt_o,
   output shf_mode_e         shf_o,
   output bld_mode_e         bld_o,
   output logic              legal_o
);

   assign amt_o   = ctrl_i[AMT_W-1:0];
   assign shf_o   = shf_mode_e'(ctrl_i[SHF_LSB +: MODE_W]);
   assign bld_o   = bld_mode_e'(ctrl_i[BLD_LSB +: MODE_W]);
   assign legal_o = (ctrl_i[SHF_LSB +: MODE_W] != SHF_RSVD);

endmodule

// File: rtl/shb_shifter.sv
module shb_shifter
   import shb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit LOG_IMPL = 1'b1,
   localparam int AMT_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opd_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  shf_mode_e         shf_i,
   output logic [DATA_W-1:0] mask_o
);

   if (LOG_IMPL) begin : g_log
      logic                          left;
      logic                          fill;
      logic [AMT_W:0][DATA_W-1:0]    stg;

      assign left   = (shf_i == SHF_LEFT);
      assign fill   = (shf_i == SHF_ARIGHT) & opd_i[DATA_W-1];
      assign stg[0] = opd_i;

      for (genvar i = 0; i < AMT_W; i++) begin : g_stage
         localparam int S = 1 << i;
         logic [DATA_W-1:0] lsh;
         logic [DATA_W-1:0] rsh;
         assign lsh = {stg[i][DATA_W-1-S:0], {S{1'b0}}};
         assign rsh = {{S{fill}}, stg[i][DATA_W-1:S]};
         assign stg[i+1] = !amt_i[i] ? stg[i] : (left ? lsh : rsh);
      end

      assign mask_o = stg[AMT_W];
   end else begin : g_direct
      always_comb begin
         unique case (shf_i)
            SHF_LEFT:   mask_o = opd_i << amt_i;
            SHF_LRIGHT: mask_o = opd_i >> amt_i;
            SHF_ARIGHT: mask_o = DATA_W'($signed(opd_i) >>> amt_i);
            default:    mask_o = opd_i;
         endcase
      end
   end

endmodule

// File: rtl/shb_blend.sv
module shb_blend
   import shb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] mask_i,
   input  bld_mode_e         bld_i,
   input  logic              legal_i,
   output logic [DATA_W-1:0] res_o
);

   logic [DATA_W-1:0] mix;

   always_comb begin
      unique case (bld_i)
         BLD_MOVE: mix = mask_i;
         BLD_AND:  mix = base_i & mask_i;
         BLD_OR:   mix = base_i | mask_i;
         BLD_XOR:  mix = base_i ^ mask_i;
         default:  mix = mask_i;
      endcase
   end

   assign res_o = legal_i ? mix : '0;

endmodule

// File: rtl/shb_hold_stage.sv
module shb_hold_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   output logic              in_ready_o,
   input  logic [DATA_W-1:0] res_i,
   input  logic              legal_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [DATA_W-1:0] res_o,
   output logic              wr_o,
   output logic              ill_o
);

   logic              vld_q;
   logic              wr_q;
   logic              ill_q;
   logic [DATA_W-1:0] res_q;
   logic              take;

   assign in_ready_o = !vld_q || out_ready_i;
   assign take       = in_valid_i && in_ready_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         wr_q  <= 1'b0;
         ill_q <= 1'b0;
         res_q <= '0;
      end else if (take) begin
         vld_q <= 1'b1;
         wr_q  <= legal_i;
         ill_q <= !legal_i;
         res_q <= res_i;
      end else if (out_ready_i) begin
         vld_q <= 1'b0;
         wr_q  <= 1'b0;
         ill_q <= 1'b0;
      end
   end

   assign out_valid_o = vld_q;
   assign res_o       = res_q;
   assign wr_o        = wr_q;
   assign ill_o       = ill_q;

endmodule

// File: rtl/shblend_unit.sv
module shblend_unit
   import shb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit LOG_IMPL = 1'b1,
   localparam int AMT_W   = $clog2(DATA_W),
   localparam int CTRL_W  = AMT_W + 2 * MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   output logic              in_ready_o,
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic              illegal_o
);

   if (!is_pow2(DATA_W) || DATA_W < 8) begin : g_bad_width
      $error("shblend_unit: DATA_W must be a power of two of at least 8");
   end

   logic [AMT_W-1:0]  amt;
   shf_mode_e         shf;
   bld_mode_e         bld;
   logic              legal;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] res_d;

   shb_ctrl_decode #(.AMT_W(AMT_W)) u_dec (
      .ctrl_i  (ctrl_i),
      .amt_o   (amt),
      .shf_o   (shf),
      .bld_o   (bld),
      .legal_o (legal)
   );

   shb_shifter #(.DATA_W(DATA_W), .LOG_IMPL(LOG_IMPL)) u_shf (
      .opd_i  (operand_i),
      .amt_i  (amt),
      .shf_i  (shf),
      .mask_o (mask)
   );

   shb_blend #(.DATA_W(DATA_W)) u_bld (
      .base_i  (base_i),
      .mask_i  (mask),
      .bld_i   (bld),
      .legal_i (legal),
      .res_o   (res_d)
   );

   shb_hold_stage #(.DATA_W(DATA_W)) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (in_valid_i),
      .in_ready_o  (in_ready_o),
      .res_i       (res_d),
      .legal_i     (legal),
      .out_valid_o (out_valid_o),
      .out_ready_i (out_ready_i),
      .res_o       (result_o),
      .wr_o        (wr_en_o),
      .ill_o       (illegal_o)
   );

endmodule

// File: rtl/shb_checker.sv
module shb_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid_i,
   input logic              in_ready_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic [DATA_W-1:0] result_o,
   input logic              wr_en_o,
   input logic              illegal_o
);

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o) && $stable(wr_en_o) && $stable(illegal_o))); // R10

   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |-> !in_ready_o); // R9

   AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_ready_o) |=> out_valid_o); // R9

   AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o); // R9

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!wr_en_o && result_o == '0)); // R6

   AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid_o |-> (!wr_en_o && !illegal_o)); // R12

   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> $onehot({wr_en_o, illegal_o})); // R12

endmodule

bind shblend_unit shb_checker #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid_i  (in_valid_i),
   .in_ready_o  (in_ready_o),
   .out_valid_o (out_valid_o),
   .out_ready_i (out_ready_i),
   .result_o    (result_o),
   .wr_en_o     (wr_en_o),
   .illegal_o   (illegal_o)
);

// File: tb/tb_shblend_unit.sv
`timescale 1ns/1ps
module tb_shblend_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid_i = 1'b0;
   logic        in_ready_o;
   logic [31:0] base_i = '0;
   logic [31:0] operand_i = '0;
   logic [8:0]  ctrl_i = '0;
   logic        out_valid_o;
   logic        out_ready_i = 1'b0;
   logic [31:0] result_o;
   logic        wr_en_o;
   logic        illegal_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shblend_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
      .base_i(base_i), .operand_i(operand_i), .ctrl_i(ctrl_i),
      .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
      .result_o(result_o), .wr_en_o(wr_en_o), .illegal_o(illegal_o)
   );

   function automatic logic [31:0] exp_res(input logic [31:0] b, input logic [31:0] o,
                                           input logic [8:0] c);
      logic [31:0] m;
      logic [4:0]  a;
      a = c[4:0];
      case (c[6:5])
         2'b00:   m = o << a;
         2'b01:   m = o >> a;
         2'b10:   m = $signed(o) >>> a;
         default: return 32'h0;
      endcase
      case (c[8:7])
         2'b00:   return m;
         2'b01:   return b & m;
         2'b10:   return b | m;
         default: return b ^ m;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_out(input string req, input logic [31:0] b, input logic [31:0] o,
                            input logic [8:0] c);
      logic ill;
      ill = (c[6:5] == 2'b11);
      check({req, " valid R9"}, 32'(out_valid_o), 32'd1);
      check({req, " result"}, result_o, exp_res(b, o, c));
      check({req, " wr_en R6/R12"}, 32'(wr_en_o), 32'(!ill));
      check({req, " illegal R6/R12"}, 32'(illegal_o), 32'(ill));
   endtask

   task automatic run_op(input string req, input logic [31:0] b, input logic [31:0] o,
                         input logic [8:0] c, input int stall);
      logic [31:0] held;
      @(negedge clk);
      base_i = b; operand_i = o; ctrl_i = c;
      in_valid_i = 1'b1;
      out_ready_i = (stall == 0);
      @(posedge clk); #1;
      in_valid_i = 1'b0;
      base_i = ~b; operand_i = ~o;
      check_out(req, b, o, c);
      held = result_o;
      for (int k = 0; k < stall; k++) begin
         check("R9 stalled in_ready", 32'(in_ready_o), 32'd0);
         @(posedge clk); #1;
         check("R10 held result", result_o, held);
         check("R10 held valid", 32'(out_valid_o), 32'd1);
      end
      out_ready_i = 1'b1;
      @(posedge clk); #1;
      check("R9 drained", 32'(out_valid_o), 32'd0);
      check("R12 flags idle", {30'd0, wr_en_o, illegal_o}, 32'd0);
      out_ready_i = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1;
      check("R11 valid", 32'(out_valid_o), 32'd0);
      check("R11 result", result_o, 32'd0);
      check("R11 flags", {30'd0, wr_en_o, illegal_o}, 32'd0);
      check("R9 ready empty", 32'(in_ready_o), 32'd1);
      @(negedge clk); rst_n = 1'b1;

      // R1 R2 R3 R4: the field layout and each shift kind, with the move blend
      run_op("R2 left", 32'h0, 32'h8000_0001, {2'b00, 2'b00, 5'd4}, 0);
      run_op("R3 logical right", 32'h0, 32'h8000_0000, {2'b00, 2'b01, 5'd31}, 1);
      run_op("R4 arith right", 32'h0, 32'h8000_0000, {2'b00, 2'b10, 5'd31}, 0);
      run_op("R4 arith positive", 32'h0, 32'h7000_0000, {2'b00, 2'b10, 5'd28}, 0);
      run_op("R2 left 31", 32'h0, 32'h0000_0003, {2'b00, 2'b00, 5'd31}, 0);
      // R5: zero amount in every legal mode
      for (int m = 0; m < 3; m++)
         run_op("R5 zero amount", 32'h0, 32'hC35A_A53C, {2'b00, 2'(m), 5'd0}, 0);
      // R7 R8: each blend against the base
      run_op("R7 move ignores base", 32'hFFFF_FFFF, 32'h0000_00F0, {2'b00, 2'b00, 5'd0}, 0);
      run_op("R8 and", 32'hF0F0_F0F0, 32'hFF00_FF00, {2'b01, 2'b01, 5'd4}, 0);
      run_op("R8 or", 32'h0000_000F, 32'h0000_0F00, {2'b10, 2'b00, 5'd4}, 0);
      run_op("R8 xor", 32'hFFFF_0000, 32'h8000_0000, {2'b11, 2'b10, 5'd15}, 2);
      // R6: reserved shift code
      run_op("R6 reserved", 32'hDEAD_BEEF, 32'h1234_5678, {2'b10, 2'b11, 5'd3}, 0);
      run_op("R6 reserved stalled", 32'hFFFF_FFFF, 32'hFFFF_FFFF, {2'b00, 2'b11, 5'd0}, 3);

      // R9: back-to-back with a ready downstream
      @(negedge clk);
      out_ready_i = 1'b1; in_valid_i = 1'b1;
      base_i = 32'h1; operand_i = 32'h10; ctrl_i = {2'b10, 2'b00, 5'd1};
      @(posedge clk); #1;
      check_out("R9 b2b first", 32'h1, 32'h10, {2'b10, 2'b00, 5'd1});
      check("R9 ready while draining", 32'(in_ready_o), 32'd1);
      base_i = 32'h0; operand_i = 32'hF000_0000; ctrl_i = {2'b00, 2'b10, 5'd8};
      @(posedge clk); #1;
      check_out("R9 b2b second", 32'h0, 32'hF000_0000, {2'b00, 2'b10, 5'd8});
      in_valid_i = 1'b0;
      @(posedge clk); #1;
      check("R9 b2b drained", 32'(out_valid_o), 32'd0);
      out_ready_i = 1'b0;

      // constrained random mix of all modes, including the reserved one
      for (int t = 0; t < 400; t++) begin
         logic [31:0] rb, ro;
         logic [8:0]  rc;
         rb = $urandom; ro = $urandom; rc = 9'($urandom);
         if (t % 8 == 0) rc[4:0] = 5'd31;
         if (t % 8 == 1) rc[4:0] = 5'd0;
         run_op("R1 random", rb, ro, rc, int'($urandom % 3));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule